// File: doc/BRIEF.md
# USB Endpoint Address Match Selector

This block chooses the endpoint buffer that serves an incoming USB token. A token is given as a decoded 7-bit device address, a 4-bit endpoint number and a token kind (OUT, IN or SETUP). The block first compares the device address with a programmed function address. If that address matches, it compares the endpoint number with seven endpoint control slots at the same time. Slot 0 is a bidirectional control endpoint, slots 1 to 3 are transmit endpoints and slots 4 to 6 are receive endpoints. The block then reports either the index of the selected slot or no match.

Each slot holds an endpoint number, an enable bit and an isochronous bit. The slots are written through a narrow configuration write port. Per-buffer full and empty flags come from the buffer storage, which is outside this block. More than one slot of the same direction may carry the same endpoint number. In that case the lowest index wins. An isochronous slot gives up its turn when its buffer is exhausted: a receive slot when its buffer is full, a transmit slot when its buffer is empty. The next matching slot then takes over, and this gives ping-pong buffering with no software action.

Tokens come in as a one-cycle strobe and are never back-pressured: the block accepts a strobe in every cycle. The result is registered, appears on the cycle after the strobe, and is held until the next strobe.

Top module: `ep_match_sel`

## Requirements
- R1: After reset, `sel_valid` is 0 and `sel_idx` is 0. The function address is disabled and every slot is disabled, so no token can match until software writes the configuration.
- R2: One clock edge after a cycle with `tok_valid` high, `sel_valid` and `sel_idx` show the decision for that token. In cycles without `tok_valid`, both outputs keep their values, whatever the token inputs do.
- R3: A token whose `tok_addr` differs from the programmed function address gives `sel_valid`=0. A token also gives `sel_valid`=0 while the function address enable bit is clear.
- R4: A slot is a candidate only if its enable bit is set and its endpoint number equals `tok_ep`. If no slot is a candidate, the result is `sel_valid`=0.
- R5: The `tok_kind` encoding is 0 = OUT, 1 = IN, 2 = SETUP and 3 = reserved. An OUT token considers only slots 0, 4, 5 and 6. An IN token considers only slots 0, 1, 2 and 3. A reserved token never matches.
- R6: A SETUP token can select only slot 0.
- R7: Among several candidates, the one with the lowest index is selected. For a slot whose isochronous bit is clear, the buffer full and empty flags have no effect on selection.
- R8: A slot whose isochronous bit is set is skipped when its buffer is exhausted. For slots 4 to 6 this means `buf_full[i]`=1. For slots 1 to 3 it means `buf_empty[i]`=1. For slot 0 it means `buf_full[0]` on OUT or SETUP tokens and `buf_empty[0]` on IN tokens. If every candidate is skipped, the result is `sel_valid`=0.
- R9: A transmit slot and a receive slot with the same endpoint number are matched independently. Each token direction selects within its own group.
- R10: When `cfg_wr`=1, `cfg_idx` 0 to 6 writes a slot with `cfg_data[3:0]` as the endpoint number, `cfg_data[4]` as enable and `cfg_data[5]` as isochronous. `cfg_idx` 7 writes the function address, with `cfg_data[6:0]` as the address and `cfg_data[7]` as enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Register select: 0 to 6 for slots, 7 for the function address |
| cfg_data | input | 8 | Configuration write data |
| tok_valid | input | 1 | Token strobe, one cycle per token |
| tok_addr | input | 7 | Decoded device address of the token |
| tok_ep | input | 4 | Endpoint number of the token |
| tok_kind | input | 2 | Token kind: 0 = OUT, 1 = IN, 2 = SETUP |
| buf_full | input | 7 | Per-slot buffer full flags |
| buf_empty | input | 7 | Per-slot buffer empty flags |
| sel_valid | output | 1 | A slot was selected for the last token |
| sel_idx | output | 3 | Index of the selected slot |

## Verification
The assertions check on every cycle the properties that hold whatever the configuration is. These are: the result is held between strobes; a wrong or disabled address never gives a match; IN, OUT and SETUP tokens select only slots of their own group; a selected slot is always enabled and carries the token's endpoint number; and an isochronous receive slot with a full buffer is never selected. Only the bench scenarios can show that the lowest index wins between duplicate numbers, that the non-isochronous choice ignores buffer status, and that the choice alternates across two consecutive OUT tokens as one isochronous buffer fills and is later drained. These outcomes depend on the exact configuration that was programmed and on the order of the tokens.

// File: rtl/ep_sel_pkg.sv
package ep_sel_pkg;
  localparam int ADDR_W = 7;
  localparam int EPN_W  = 4;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_RSVD  = 2'd3
  } tok_kind_e;

  // one endpoint control slot; bit layout matches the write port
  typedef struct packed {
    logic             iso;
    logic             en;
    logic [EPN_W-1:0] num;
  } ep_cfg_t;

  localparam int SLOT_W = $bits(ep_cfg_t);
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_sel_pkg::*;
#(
  parameter int N_EP      = 7,
  parameter int CFG_IDX_W = $clog2(N_EP + 1),
  parameter int CFG_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [CFG_IDX_W-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]       cfg_data,
  output logic [ADDR_W-1:0]      fa_addr,
  output logic                   fa_en,
  output ep_cfg_t [N_EP-1:0]     ep_cfg
);
  localparam logic [CFG_IDX_W-1:0] FA_SLOT = CFG_IDX_W'(N_EP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_addr <= '0;
      fa_en   <= 1'b0;
      ep_cfg  <= '0;
    end else if (cfg_wr) begin
      if (cfg_idx == FA_SLOT) begin
        fa_addr <= cfg_data[ADDR_W-1:0];
        fa_en   <= cfg_data[ADDR_W];
      end
      for (int i = 0; i < N_EP; i++) begin
        if (cfg_idx == CFG_IDX_W'(i)) ep_cfg[i] <= ep_cfg_t'(cfg_data[SLOT_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/ep_addr_gate.sv
module ep_addr_gate
  import ep_sel_pkg::*;
(
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [ADDR_W-1:0] fa_addr,
  input  logic              fa_en,
  output logic              addr_hit
);
  always_comb addr_hit = fa_en && (tok_addr == fa_addr);
endmodule

// File: rtl/ep_cand_vec.sv
module ep_cand_vec
  import ep_sel_pkg::*;
#(
  parameter int N_TX = 3,
  parameter int N_RX = 3,
  localparam int N_EP = 1 + N_TX + N_RX
) (
  input  logic              addr_hit,
  input  logic [EPN_W-1:0]  tok_ep,
  input  logic [1:0]        tok_kind,
  input  ep_cfg_t [N_EP-1:0] ep_cfg,
  input  logic [N_EP-1:0]   buf_full,
  input  logic [N_EP-1:0]   buf_empty,
  output logic [N_EP-1:0]   cand
);
  logic k_out, k_in, k_setup;
  always_comb begin
    k_out   = (tok_kind == TK_OUT);
    k_in    = (tok_kind == TK_IN);
    k_setup = (tok_kind == TK_SETUP);
  end

  for (genvar i = 0; i < N_EP; i++) begin : g_slot
    logic dir_ok, drained, num_hit;
    always_comb num_hit = ep_cfg[i].en && (ep_cfg[i].num == tok_ep);
    if (i == 0) begin : g_bidir
      always_comb begin
        dir_ok  = k_out || k_in || k_setup;
        drained = k_in ? buf_empty[i] : buf_full[i];
      end
    end else if (i <= N_TX) begin : g_tx
      always_comb begin
        dir_ok  = k_in;
        drained = buf_empty[i];
      end
    end else begin : g_rx
      always_comb begin
        dir_ok  = k_out;
        drained = buf_full[i];
      end
    end
    always_comb cand[i] = addr_hit && num_hit && dir_ok && !(ep_cfg[i].iso && drained);
  end
endmodule

// File: rtl/ep_prio_pick.sv
module ep_prio_pick #(
  parameter int N_EP  = 7,
  localparam int IDX_W = $clog2(N_EP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EP-1:0]  cand,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_EP - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R7: the granted slot is a real candidate
  p_grant_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cand[idx]);
  // R7: no lower-index candidate is passed over
  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((cand & ((N_EP'(1) << idx) - N_EP'(1))) == '0));
endmodule

// File: rtl/ep_match_sel.sv
module ep_match_sel
  import ep_sel_pkg::*;
#(
  parameter int N_TX  = 3,
  parameter int N_RX  = 3,
  localparam int N_EP      = 1 + N_TX + N_RX,
  localparam int IDX_W     = $clog2(N_EP),
  localparam int CFG_IDX_W = $clog2(N_EP + 1),
  localparam int CFG_W     = (ADDR_W + 1 > SLOT_W) ? ADDR_W + 1 : SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 tok_valid,
  input  logic [ADDR_W-1:0]    tok_addr,
  input  logic [EPN_W-1:0]     tok_ep,
  input  logic [1:0]           tok_kind,
  input  logic [N_EP-1:0]      buf_full,
  input  logic [N_EP-1:0]      buf_empty,
  output logic                 sel_valid,
  output logic [IDX_W-1:0]     sel_idx
);
  localparam logic [IDX_W-1:0] LAST_TX = IDX_W'(N_TX);

  logic [ADDR_W-1:0]  fa_addr;
  logic               fa_en;
  ep_cfg_t [N_EP-1:0] ep_cfg;
  logic               addr_hit;
  logic [N_EP-1:0]    cand;
  logic               pick_hit;
  logic [IDX_W-1:0]   pick_idx;

  ep_cfg_regs #(.N_EP(N_EP), .CFG_IDX_W(CFG_IDX_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .fa_addr(fa_addr), .fa_en(fa_en), .ep_cfg(ep_cfg)
  );

  ep_addr_gate u_addr (
    .tok_addr(tok_addr), .fa_addr(fa_addr), .fa_en(fa_en), .addr_hit(addr_hit)
  );

  ep_cand_vec #(.N_TX(N_TX), .N_RX(N_RX)) u_cand (
    .addr_hit(addr_hit), .tok_ep(tok_ep), .tok_kind(tok_kind), .ep_cfg(ep_cfg),
    .buf_full(buf_full), .buf_empty(buf_empty), .cand(cand)
  );

  ep_prio_pick #(.N_EP(N_EP)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .hit(pick_hit), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else if (tok_valid) begin
      sel_valid <= pick_hit;
      sel_idx   <= pick_idx;
    end
  end

  // R2: result held between strobes
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> ($stable(sel_valid) && $stable(sel_idx)));
  // R3: wrong or disabled address never matches
  p_addr_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && (!fa_en || tok_addr != fa_addr)) |=> !sel_valid);
  // R4: a chosen slot is enabled and carries the token endpoint number
  p_slot_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pick_hit |-> (ep_cfg[pick_idx].en && ep_cfg[pick_idx].num == tok_ep));
  // R5: IN tokens stay in the transmit group
  p_in_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_IN) |=> (!sel_valid || sel_idx <= LAST_TX));
  // R5: OUT tokens stay in the receive group
  p_out_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_OUT) |=> (!sel_valid || sel_idx == '0 || sel_idx > LAST_TX));
  // R5: reserved kind never matches
  p_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_RSVD) |=> !sel_valid);
  // R6: SETUP goes only to slot 0
  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_SETUP) |=> (!sel_valid || sel_idx == '0));
  // R8: a full isochronous receive slot is never chosen
  p_iso_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_hit && pick_idx > LAST_TX && ep_cfg[pick_idx].iso) |-> !buf_full[pick_idx]);
endmodule

// File: tb/test_ep_match_sel.sv
module test_ep_match_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic       tok_valid = 1'b0;
  logic [6:0] tok_addr = '0;
  logic [3:0] tok_ep = '0;
  logic [1:0] tok_kind = '0;
  logic [6:0] buf_full = '0;
  logic [6:0] buf_empty = '0;
  logic       sel_valid;
  logic [2:0] sel_idx;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       v;
    logic [2:0] idx;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  ep_match_sel i_ep_match_sel (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .tok_valid(tok_valid), .tok_addr(tok_addr),
    .tok_ep(tok_ep), .tok_kind(tok_kind), .buf_full(buf_full),
    .buf_empty(buf_empty), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_RSVD = 2'd3;

  task automatic wcfg(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_data = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic tok(input logic [6:0] a, input logic [3:0] ep, input logic [1:0] k,
                     input logic ev, input logic [2:0] ei, input string req);
    exp_t e;
    e.v = ev; e.idx = ei; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    tok_addr = a; tok_ep = ep; tok_kind = k; tok_valid = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compares the registered result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (tok_valid) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL %s actual result with no expectation expected none", "R2");
        end else begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (sel_valid !== e.v || (e.v && sel_idx !== e.idx)) begin
            errors++;
            $display("FAIL %s actual valid=%0b idx=%0d expected valid=%0b idx=%0d",
                     e.req, sel_valid, sel_idx, e.v, e.idx);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sel_valid !== 1'b0 || sel_idx !== 3'd0) begin
      errors++;
      $display("FAIL R1 actual valid=%0b idx=%0d expected valid=0 idx=0", sel_valid, sel_idx);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3: address register reset to disabled, so even address 0 misses
    tok(7'h00, 4'd0, K_OUT, 1'b0, 3'd0, "R3");
    // R10: function address, enable in bit 7
    wcfg(3'd7, {1'b1, DEV});
    // R1: all slots come out of reset disabled
    tok(DEV, 4'd0, K_OUT, 1'b0, 3'd0, "R1");

    // R10: slot layout {iso, en, num[3:0]}
    wcfg(3'd0, 8'h10);  // slot0 ep0
    wcfg(3'd1, 8'h11);  // tx1 ep1
    wcfg(3'd4, 8'h11);  // rx4 ep1
    wcfg(3'd2, 8'h13);  // tx2 ep3
    wcfg(3'd3, 8'h13);  // tx3 ep3 (duplicate)
    wcfg(3'd5, 8'h32);  // rx5 ep2 iso
    wcfg(3'd6, 8'h32);  // rx6 ep2 iso

    tok(7'h2B, 4'd1, K_OUT, 1'b0, 3'd0, "R3");
    tok(DEV, 4'd1, K_OUT, 1'b1, 3'd4, "R9");
    tok(DEV, 4'd1, K_IN, 1'b1, 3'd1, "R9");
    tok(DEV, 4'd0, K_SETUP, 1'b1, 3'd0, "R6");
    tok(DEV, 4'd1, K_SETUP, 1'b0, 3'd0, "R6");
    tok(DEV, 4'd0, K_IN, 1'b1, 3'd0, "R5");
    tok(DEV, 4'd1, K_RSVD, 1'b0, 3'd0, "R5");
    tok(DEV, 4'd3, K_OUT, 1'b0, 3'd0, "R5");

    // R2: outputs hold while token inputs move without a strobe
    tok(DEV, 4'd3, K_IN, 1'b1, 3'd2, "R7");
    @(negedge clk);
    tok_addr = 7'h11; tok_ep = 4'd1; tok_kind = K_OUT;
    repeat (3) @(negedge clk);
    checks++;
    if (sel_valid !== 1'b1 || sel_idx !== 3'd2) begin
      errors++;
      $display("FAIL R2 actual valid=%0b idx=%0d expected valid=1 idx=2", sel_valid, sel_idx);
    end

    // R7: non-iso slot ignores empty status
    buf_empty[2] = 1'b1;
    tok(DEV, 4'd3, K_IN, 1'b1, 3'd2, "R7");
    buf_empty[2] = 1'b0;
    // R4: disabled slot skipped, duplicate takes over
    wcfg(3'd2, 8'h03);
    tok(DEV, 4'd3, K_IN, 1'b1, 3'd3, "R4");
    tok(DEV, 4'd9, K_OUT, 1'b0, 3'd0, "R4");

    // R8: isochronous ping-pong across consecutive OUT tokens
    tok(DEV, 4'd2, K_OUT, 1'b1, 3'd5, "R8");
    buf_full[5] = 1'b1;
    tok(DEV, 4'd2, K_OUT, 1'b1, 3'd6, "R8");
    buf_full[6] = 1'b1;
    tok(DEV, 4'd2, K_OUT, 1'b0, 3'd0, "R8");
    buf_full[5] = 1'b0;
    tok(DEV, 4'd2, K_OUT, 1'b1, 3'd5, "R8");
    buf_full = '0;

    // R8: isochronous transmit slot skipped while empty
    wcfg(3'd1, 8'h31);
    buf_empty[1] = 1'b1;
    tok(DEV, 4'd1, K_IN, 1'b0, 3'd0, "R8");
    buf_empty[1] = 1'b0;
    tok(DEV, 4'd1, K_IN, 1'b1, 3'd1, "R8");

    // R3: function address disabled blocks a matching address
    wcfg(3'd7, {1'b0, DEV});
    tok(DEV, 4'd1, K_OUT, 1'b0, 3'd0, "R3");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 actual pending=%0d expected pending=0", sb.size());
    end
    finish_run();
  end
endmodule